// File: doc/BRIEF.md
# Swap and Inversion Tolerant Two-Wire Receiver

This block recovers a serial bit stream from a two-wire transition-coded link. On a link of this kind the sender moves at least one wire every bit period. A one is sent by moving both wires, and a zero by moving exactly one. The wiring between sender and receiver may cross the two lines, and it may invert either line. Whichever of these faults is present stays fixed for the session, and the receiver is not told which one. It does not need to know. A crossing or an inversion changes what level a wire shows, but it never changes whether that wire moved between two samples.

The receiver keeps the previous sample of each wire. On every clock it compares the present levels with that stored pair and counts how many wires moved. The decision is registered, so the recovered bit trails the sent bit by two clock edges from end to end: one in the sender and one here. The first interval after reset only loads the stored pair, and a valid flag rises one interval later. An interval in which neither wire moved breaks the line code. Such an interval is reported on an error flag and decodes as zero.

Top module: `flip_tolerant_rx`

## Requirements
- R1: While rst_n is low, data_out, data_valid and line_err are all 0.
- R2: After reset is released, data_valid stays 0 for the first clock edge and becomes 1 from the second edge on. It then remains 1 until the next reset.
- R3: When data_valid is 1 and both line_a and line_b differ from their values at the previous edge, the next edge sets data_out to 1 and line_err to 0.
- R4: When data_valid is 1 and exactly one of line_a and line_b differs from its value at the previous edge, the next edge sets data_out to 0 and line_err to 0.
- R5: When data_valid is 1 and neither line differs from its value at the previous edge, the next edge sets line_err to 1 and data_out to 0.
- R6: A sender toggles wire one every period and toggles wire two when the data bit is 1. Behind that sender, and for every one of the eight combinations of wire crossing and per-wire inversion, data_out equals the sent bit two clock edges earlier, and line_err stays 0.
- R7: line_err is never 1 while data_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_a | input | 1 | First received wire |
| line_b | input | 1 | Second received wire |
| data_out | output | 1 | Recovered data bit |
| data_valid | output | 1 | High when data_out carries a decoded bit |
| line_err | output | 1 | High for an interval in which neither wire moved |

## Verification
Each decision appears one edge after the wire levels it is based on, which makes it two edges behind the data bit fed to the bench's sender. The bench drives all inputs at the falling edge and samples at the falling edge. At each falling edge it compares the outputs with the bit or wire pair it drove two falling edges earlier. The valid flag is checked at the first falling edge after reset is released, where it must still be low, and from the next falling edge on, where it must be high. Directed wire patterns cover the both-moved, one-moved and none-moved cases. These are followed by random wire pairs and then by eight end-to-end runs from a pseudo-random bit source, one for each crossing and inversion setting.

// File: rtl/flip_tolerant_rx.sv
module flip_tolerant_rx (
  input  logic clk,
  input  logic rst_n,
  input  logic line_a,
  input  logic line_b,
  output logic data_out,
  output logic data_valid,
  output logic line_err
);

  logic prev_a, prev_b, primed;

  wire moved_a = line_a ^ prev_a;
  wire moved_b = line_b ^ prev_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a     <= 1'b0;
      prev_b     <= 1'b0;
      primed     <= 1'b0;
      data_valid <= 1'b0;
      data_out   <= 1'b0;
      line_err   <= 1'b0;
    end else begin
      prev_a     <= line_a;
      prev_b     <= line_b;
      primed     <= 1'b1;
      data_valid <= primed;
      data_out   <= primed & moved_a & moved_b;
      line_err   <= primed & ~(moved_a | moved_b);
    end
  end

endmodule

// File: rtl/flip_tolerant_rx_chk.sv
module flip_tolerant_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic line_a,
  input logic line_b,
  input logic data_out,
  input logic data_valid,
  input logic line_err
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!data_out && !data_valid && !line_err));

  p_valid_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> data_valid);

  p_both_moved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && line_a != $past(line_a) && line_b != $past(line_b))
    |=> (data_out && !line_err));

  p_one_moved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && ((line_a != $past(line_a)) != (line_b != $past(line_b))))
    |=> (!data_out && !line_err));

  p_none_moved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $stable(line_a) && $stable(line_b))
    |=> (line_err && !data_out));

  p_err_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |-> data_valid);

endmodule

bind flip_tolerant_rx flip_tolerant_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
  .data_out(data_out), .data_valid(data_valid), .line_err(line_err)
);

// File: tb/tb_flip_tolerant_rx.sv
module tb_flip_tolerant_rx;

  localparam int RUN_LEN  = 300;
  localparam int RAND_LEN = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic direct_mode = 1'b1;
  logic drv_a = 1'b0, drv_b = 1'b0;
  logic din = 1'b0;
  logic swap = 1'b0, inv_a = 1'b0, inv_b = 1'b0;
  logic tx1, tx2;
  logic line_a, line_b;
  logic data_out, data_valid, line_err;

  int checks = 0;
  int errors = 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx1 <= 1'b0;
      tx2 <= 1'b0;
    end else begin
      tx1 <= ~tx1;
      tx2 <= tx2 ^ din;
    end
  end

  wire chan_a = (swap ? tx2 : tx1) ^ inv_a;
  wire chan_b = (swap ? tx1 : tx2) ^ inv_b;
  assign line_a = direct_mode ? drv_a : chan_a;
  assign line_b = direct_mode ? drv_b : chan_b;

  flip_tolerant_rx dut (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
    .data_out(data_out), .data_valid(data_valid), .line_err(line_err)
  );

  function automatic logic [1:0] expect_dec(input logic [1:0] older, input logic [1:0] newer);
    logic [1:0] m;
    m = older ^ newer;
    if (m == 2'b11) return 2'b10;
    if (m == 2'b00) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drv_a = 1'b0;
    drv_b = 1'b0;
    din = 1'b0;
    #1;
    chk("R1", "data_out in reset", data_out, 1'b0);
    chk("R1", "data_valid in reset", data_valid, 1'b0);
    chk("R1", "line_err in reset", line_err, 1'b0);
    repeat (2) @(negedge clk);
    chk("R1", "data_valid held in reset", data_valid, 1'b0);
  endtask

  task automatic wire_run(input int n, input logic [1:0] seq []);
    logic [1:0] hist [$];
    logic [1:0] e;
    direct_mode = 1'b1;
    do_reset();
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) chk("R2", "valid after first edge", data_valid, 1'b0);
      if (i >= 2) begin
        e = expect_dec(hist[i-2], hist[i-1]);
        chk("R2", "valid from second edge", data_valid, 1'b1);
        chk(e[1] ? "R3" : (e[0] ? "R5" : "R4"), "data_out", data_out, e[1]);
        chk(e[0] ? "R5" : "R4", "line_err", line_err, e[0]);
        if (line_err && !data_valid) chk("R7", "err without valid", 1'b1, 1'b0);
      end
      if (i < seq.size()) hist.push_back(seq[i]);
      else hist.push_back(2'($urandom_range(3)));
      {drv_a, drv_b} = hist[i];
      if (i == 0) rst_n = 1'b1;
    end
  endtask

  task automatic link_run(input logic s, input logic ia, input logic ib);
    logic [6:0] lfsr;
    logic hist [$];
    string tag;
    direct_mode = 1'b0;
    swap = s; inv_a = ia; inv_b = ib;
    tag = $sformatf("swap%0d inv%0d%0d", s, ia, ib);
    do_reset();
    lfsr = 7'(($urandom % 127) + 1);
    for (int i = 0; i < RUN_LEN; i++) begin
      if (i > 0) @(negedge clk);
      if (i >= 2) begin
        chk("R6", {tag, " data_out"}, data_out, hist[i-2]);
        chk("R6", {tag, " line_err"}, line_err, 1'b0);
        chk("R2", {tag, " valid"}, data_valid, 1'b1);
      end
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      din = lfsr[0];
      hist.push_back(din);
      if (i == 0) rst_n = 1'b1;
    end
  endtask

  initial begin
    logic [1:0] directed [] = '{2'b00, 2'b11, 2'b10, 2'b10, 2'b01, 2'b00,
                                2'b00, 2'b11, 2'b11, 2'b01, 2'b10, 2'b10};
    logic [1:0] none [] = '{};
    void'($urandom(32'd20240611));
    wire_run(directed.size() + 2, directed);
    wire_run(RAND_LEN, none);
    for (int k = 0; k < 8; k++) link_run(k[2], k[1], k[0]);
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule